// File: doc/BRIEF.md
# Adaptive Slip Control Buffer Manager

This block watches the fill level of circular descriptor rings, one ring per channel. On each ring a cell-receive writer fills descriptors and a TDM reader drains them. Each channel keeps a signed fill counter. An accepted writer close adds one, an accepted reader close takes one away, and a close on both sides in the same cycle leaves the counter where it was. The counter also serves as a status word from which software can estimate slip.

Each channel has two pairs of thresholds with hysteresis. When the writer gets too far ahead it is held. Once the ring has drained enough, the writer is released and its pointer jumps to the descriptor just after the last one it tagged as the end of a superframe. A resynchronization phase then starts. In unstructured mode any valid cell ends that phase. In structured mode the cell must also carry a valid pointer. When the ring runs too low the reader is held, and it is released once the fill has built back up, so the reader-side gap works as a jitter buffer.

Thresholds are kept in a table of 8-byte records, one record per channel, that is written one byte at a time. A registered flag marks any channel whose reader gap is smaller than its frame length.

Top module: `slip_ctrl`

## Requirements
- R1: For each channel, `cnt` holds accepted writer closes minus accepted reader closes as a signed value. A writer close and a reader close in the same cycle leave it unchanged.
- R2: When the updated count is at or above the writer-stop threshold, `wr_hold` is set on the same edge. While `wr_hold` or `wr_resync` is high, writer closes are ignored and do not move `wr_ptr`.
- R3: While held, the writer is released on the edge where the updated count falls to or below the writer-start threshold. On that edge `wr_hold` clears, `wr_resync` sets, and `wr_ptr` becomes (index of the last writer-closed descriptor tagged `wr_eosf`) + 1 mod RING. After reset that index is RING-1.
- R4: While `wr_resync` is high, a cycle with `cell_valid` ends resynchronization on the next edge and pulses `resync_done` for one cycle. In structured mode (record byte 4 bit 7 = 1), `cell_ptr_ok` must also be high.
- R5: `rd_hold` sets when the updated count is at or below the reader-stop threshold and clears when it reaches the reader-start threshold. Reader closes are ignored while it is held. `rd_repeat` equals `rd_hold` ANDed with record byte 4 bit 6.
- R6: Record byte k of channel c is at address BASE + 8*c + k. The bytes are: 0 writer-stop, 1 writer-start, 2 reader-stop, 3 reader-start, 4 = {structured, repeat, frame[5:0]}. Thresholds are signed 8-bit. Bytes 5 to 7 and addresses outside the table are ignored.
- R7: `cfg_err[c]` goes high two edges after a write that makes reader-start minus reader-stop (signed) smaller than the frame length.
- R8: While `rst` is high, every counter, hold, resync, repeat and error flag reads 0 and both pointers read 0. Thresholds return to their defaults: 14, 8, 1, 6, and frame 4 with both mode bits clear.
- R9: `wr_ptr` and `rd_ptr` advance by one, modulo RING, on each accepted close.
- R10: Channels are independent: events on one channel never change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold table byte write strobe |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | 8 | Byte to write |
| wr_close | input | NCH | Writer closes a descriptor, per channel |
| wr_eosf | input | NCH | The descriptor being closed ends a superframe |
| rd_close | input | NCH | Reader closes a descriptor, per channel |
| cell_valid | input | NCH | A valid cell arrived for the channel |
| cell_ptr_ok | input | NCH | The arriving cell carries a valid structure pointer |
| cnt | output | NCH x CNT_W | Signed fill counter per channel |
| wr_hold | output | NCH | Writer held |
| rd_hold | output | NCH | Reader held |
| rd_repeat | output | NCH | Reader held in repeat mode (otherwise idle) |
| wr_resync | output | NCH | Writer waiting to resynchronize |
| resync_done | output | NCH | One-cycle pulse when resynchronization ends |
| wr_ptr | output | NCH x PTR_W | Writer descriptor index |
| rd_ptr | output | NCH x PTR_W | Reader descriptor index |
| cfg_err | output | NCH | Reader gap smaller than frame length |

## Verification
The assertions assume the thresholds are ordered sensibly: writer-start below writer-stop, reader-stop below reader-start, and both windows inside the counter range. Under that ordering a held side can only push the count the other way, and a release always coincides with a resynchronization. The stimulus only programs records that keep this ordering. Every close pulse is a single-cycle strobe per channel, and the only record that breaks the reader-gap rule is used to exercise the error flag, on a channel that carries no traffic.

// File: rtl/slip_pkg.sv
package slip_pkg;

  typedef struct packed {
    logic [7:0] wr_stop;
    logic [7:0] wr_start;
    logic [7:0] rd_stop;
    logic [7:0] rd_start;
    logic       structured;
    logic       repeat_en;
    logic [5:0] frame;
  } thr_t;

  localparam int REC_BYTES = 8;
  localparam int REC_USED  = 5;

  localparam thr_t THR_DEFAULT = '{
    wr_stop:    8'd14,
    wr_start:   8'd8,
    rd_stop:    8'd1,
    rd_start:   8'd6,
    structured: 1'b0,
    repeat_en:  1'b0,
    frame:      6'd4
  };

endpackage

// File: rtl/slip_thr_table.sv
module slip_thr_table
  import slip_pkg::*;
#(
  parameter int                NCH    = 4,
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  output thr_t [NCH-1:0]             thr,
  output logic [NCH-1:0]             cfg_err
);

  localparam int CH_W   = $clog2(NCH);
  localparam int SPAN   = NCH * REC_BYTES;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [CH_W-1:0]   ch_sel;
  logic [2:0]        byte_sel;

  // offset from the table base; a hit needs the address at or above base
  // and below the end of the last record
  assign off      = cfg_addr - BASE;
  assign hit      = cfg_we && (cfg_addr >= BASE) && (32'(off) < SPAN);
  assign ch_sel   = off[CH_W+2:3];
  assign byte_sel = off[2:0];

  for (genvar c = 0; c < NCH; c++) begin : g_rec
    thr_t        rec_q;
    logic signed [8:0] gap;

    always_ff @(posedge clk) begin
      if (rst) begin
        rec_q <= THR_DEFAULT;
      end else if (hit && (ch_sel == CH_W'(c))) begin
        case (byte_sel)
          3'd0: rec_q.wr_stop  <= cfg_wdata;
          3'd1: rec_q.wr_start <= cfg_wdata;
          3'd2: rec_q.rd_stop  <= cfg_wdata;
          3'd3: rec_q.rd_start <= cfg_wdata;
          3'd4: begin
            rec_q.structured <= cfg_wdata[7];
            rec_q.repeat_en  <= cfg_wdata[6];
            rec_q.frame      <= cfg_wdata[5:0];
          end
          default: ;
        endcase
      end
    end

    // reader gap must cover at least one frame
    assign gap = $signed({rec_q.rd_start[7], rec_q.rd_start})
               - $signed({rec_q.rd_stop[7], rec_q.rd_stop});

    always_ff @(posedge clk) begin
      if (rst) cfg_err[c] <= 1'b0;
      else     cfg_err[c] <= (gap < $signed({3'b000, rec_q.frame}));
    end

    assign thr[c] = rec_q;
  end

endmodule

// File: rtl/slip_chan.sv
module slip_chan
  import slip_pkg::*;
#(
  parameter int RING  = 16,
  parameter int CNT_W = 8,
  localparam int PTR_W = $clog2(RING)
) (
  input  logic             clk,
  input  logic             rst,
  input  thr_t             thr,
  input  logic             wr_close,
  input  logic             wr_eosf,
  input  logic             rd_close,
  input  logic             cell_valid,
  input  logic             cell_ptr_ok,
  output logic [CNT_W-1:0] cnt,
  output logic             wr_hold,
  output logic             rd_hold,
  output logic             rd_repeat,
  output logic             wr_resync,
  output logic             resync_done,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);

  logic signed [CNT_W-1:0] cnt_q, cnt_n;
  logic signed [CNT_W-1:0] t_wsp, t_wst, t_rsp, t_rst;
  logic                    wh_q, wh_n, rh_q, rh_n, rs_q, rs_n;
  logic                    rep_q, done_q;
  logic [PTR_W-1:0]        wp_q, wp_n, rp_q, eosf_q;
  logic                    wr_acc, rd_acc, release_w, match;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (32'(p) == RING - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic signed [CNT_W-1:0] sx(input logic [7:0] b);
    return CNT_W'($signed(b));
  endfunction

  assign t_wsp = sx(thr.wr_stop);
  assign t_wst = sx(thr.wr_start);
  assign t_rsp = sx(thr.rd_stop);
  assign t_rst = sx(thr.rd_start);

  assign wr_acc = wr_close && !wh_q && !rs_q;
  assign rd_acc = rd_close && !rh_q;

  always_comb begin
    cnt_n = cnt_q;
    if (wr_acc && !rd_acc) cnt_n = cnt_q + 1'b1;
    if (rd_acc && !wr_acc) cnt_n = cnt_q - 1'b1;
  end

  // writer hysteresis on post-update count
  assign release_w = wh_q && (cnt_n <= t_wst);
  assign wh_n      = wh_q ? !release_w : (!rs_q && (cnt_n >= t_wsp));

  // resync completion depends on mode
  assign match = cell_valid && (!thr.structured || cell_ptr_ok);
  assign rs_n  = release_w ? 1'b1 : (rs_q && !match);

  // reader hysteresis on post-update count
  assign rh_n = rh_q ? !(cnt_n >= t_rst) : (cnt_n <= t_rsp);

  always_comb begin
    wp_n = wp_q;
    if (release_w)   wp_n = inc(eosf_q);
    else if (wr_acc) wp_n = inc(wp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wh_q   <= 1'b0;
      rh_q   <= 1'b0;
      rs_q   <= 1'b0;
      rep_q  <= 1'b0;
      done_q <= 1'b0;
      wp_q   <= '0;
      rp_q   <= '0;
      eosf_q <= PTR_W'(RING - 1);
    end else begin
      cnt_q  <= cnt_n;
      wh_q   <= wh_n;
      rh_q   <= rh_n;
      rs_q   <= rs_n;
      rep_q  <= rh_n && thr.repeat_en;
      done_q <= rs_q && match && !release_w;
      wp_q   <= wp_n;
      if (rd_acc) rp_q <= inc(rp_q);
      if (wr_acc && wr_eosf) eosf_q <= wp_q;
    end
  end

  assign cnt         = cnt_q;
  assign wr_hold     = wh_q;
  assign rd_hold     = rh_q;
  assign rd_repeat   = rep_q;
  assign wr_resync   = rs_q;
  assign resync_done = done_q;
  assign wr_ptr      = wp_q;
  assign rd_ptr      = rp_q;

endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
  import slip_pkg::*;
#(
  parameter int                NCH    = 4,
  parameter int                RING   = 16,
  parameter int                CNT_W  = 8,
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h100,
  localparam int               PTR_W  = $clog2(RING)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  input  logic [NCH-1:0]              wr_close,
  input  logic [NCH-1:0]              wr_eosf,
  input  logic [NCH-1:0]              rd_close,
  input  logic [NCH-1:0]              cell_valid,
  input  logic [NCH-1:0]              cell_ptr_ok,
  output logic [NCH-1:0][CNT_W-1:0]   cnt,
  output logic [NCH-1:0]              wr_hold,
  output logic [NCH-1:0]              rd_hold,
  output logic [NCH-1:0]              rd_repeat,
  output logic [NCH-1:0]              wr_resync,
  output logic [NCH-1:0]              resync_done,
  output logic [NCH-1:0][PTR_W-1:0]   wr_ptr,
  output logic [NCH-1:0][PTR_W-1:0]   rd_ptr,
  output logic [NCH-1:0]              cfg_err
);

  thr_t [NCH-1:0] thr;

  slip_thr_table #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .thr       (thr),
    .cfg_err   (cfg_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    slip_chan #(.RING(RING), .CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .thr         (thr[c]),
      .wr_close    (wr_close[c]),
      .wr_eosf     (wr_eosf[c]),
      .rd_close    (rd_close[c]),
      .cell_valid  (cell_valid[c]),
      .cell_ptr_ok (cell_ptr_ok[c]),
      .cnt         (cnt[c]),
      .wr_hold     (wr_hold[c]),
      .rd_hold     (rd_hold[c]),
      .rd_repeat   (rd_repeat[c]),
      .wr_resync   (wr_resync[c]),
      .resync_done (resync_done[c]),
      .wr_ptr      (wr_ptr[c]),
      .rd_ptr      (rd_ptr[c])
    );
  end

endmodule

// File: rtl/slip_ctrl_chk.sv
module slip_ctrl_chk #(
  parameter int NCH   = 4,
  parameter int RING  = 16,
  parameter int CNT_W = 8,
  parameter int PTR_W = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0]            wr_hold,
  input logic [NCH-1:0]            rd_hold,
  input logic [NCH-1:0]            wr_resync,
  input logic [NCH-1:0]            resync_done,
  input logic [NCH-1:0][PTR_W-1:0] wr_ptr
);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (32'(p) == RING - 1) ? '0 : p + 1'b1;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R1: count moves by at most one per cycle
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
      ($signed(cnt[c]) <= $signed($past(cnt[c])) + 1) &&
      ($signed(cnt[c]) >= $signed($past(cnt[c])) - 1));

    // R2: a held writer cannot raise the count
    p_wr_hold_no_rise_r2: assert property (@(posedge clk) disable iff (rst)
      wr_hold[c] |=> $signed(cnt[c]) <= $signed($past(cnt[c])));

    // R3: writer release starts resynchronization
    p_release_resync_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_hold[c]) |-> wr_resync[c]);

    // R4: resync ends only with a done pulse
    p_resync_done_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_resync[c]) |-> resync_done[c]);

    // R5: a held reader cannot lower the count
    p_rd_hold_no_fall_r5: assert property (@(posedge clk) disable iff (rst)
      rd_hold[c] |=> $signed(cnt[c]) >= $signed($past(cnt[c])));

    // R9: writer pointer steps by one unless a release jump happens
    p_wr_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
      !$fell(wr_hold[c]) |->
        (wr_ptr[c] == $past(wr_ptr[c])) || (wr_ptr[c] == nxt($past(wr_ptr[c]))));
  end

endmodule

bind slip_ctrl slip_ctrl_chk #(
  .NCH(NCH), .RING(RING), .CNT_W(CNT_W), .PTR_W(PTR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt         (cnt),
  .wr_hold     (wr_hold),
  .rd_hold     (rd_hold),
  .wr_resync   (wr_resync),
  .resync_done (resync_done),
  .wr_ptr      (wr_ptr)
);

// File: tb/tb_slip_ctrl.sv
module tb_slip_ctrl;

  localparam int NCH = 4, RING = 16, CNT_W = 8, ADDR_W = 10, PTR_W = 4;
  localparam logic [ADDR_W-1:0] BASE = 10'h100;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NCH-1:0] wr_close = '0, wr_eosf = '0, rd_close = '0, cell_valid = '0, cell_ptr_ok = '0;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [NCH-1:0] wr_hold, rd_hold, rd_repeat, wr_resync, resync_done, cfg_err;
  logic [NCH-1:0][PTR_W-1:0] wr_ptr, rd_ptr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  slip_ctrl #(.NCH(NCH), .RING(RING), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE(BASE)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wr_close(wr_close), .wr_eosf(wr_eosf), .rd_close(rd_close),
    .cell_valid(cell_valid), .cell_ptr_ok(cell_ptr_ok),
    .cnt(cnt), .wr_hold(wr_hold), .rd_hold(rd_hold), .rd_repeat(rd_repeat),
    .wr_resync(wr_resync), .resync_done(resync_done),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cfg_err(cfg_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wcfg(input int addr, input logic [7:0] d);
    cfg_we = 1; cfg_addr = ADDR_W'(addr); cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  // vector: wr rd eosf cv po | cnt[7:0] wh rh rs rep | wp[3:0] rp[3:0]
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {5'b10000, 8'd1, 4'b0101, 4'd1, 4'd0},  // v0  R1 R5 R9
    {5'b11000, 8'd2, 4'b0000, 4'd2, 4'd0},  // v1  R5 rd ignored, release
    {5'b10100, 8'd3, 4'b0000, 4'd3, 4'd0},  // v2  eosf tag
    {5'b11000, 8'd3, 4'b0000, 4'd4, 4'd1},  // v3  R1 simultaneous
    {5'b10000, 8'd4, 4'b1000, 4'd5, 4'd1},  // v4  R2 hold
    {5'b10000, 8'd4, 4'b1000, 4'd5, 4'd1},  // v5  R2 ignored
    {5'b01000, 8'd3, 4'b1000, 4'd5, 4'd2},  // v6
    {5'b01000, 8'd2, 4'b0010, 4'd3, 4'd3},  // v7  R3 jump
    {5'b10010, 8'd2, 4'b0000, 4'd3, 4'd3},  // v8  R4 unstructured
    {5'b01000, 8'd1, 4'b0000, 4'd3, 4'd4},  // v9
    {5'b01000, 8'd0, 4'b0101, 4'd3, 4'd5},  // v10 R5 hold + repeat
    {5'b01000, 8'd0, 4'b0101, 4'd3, 4'd5}   // v11 R5 ignored
  };

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R8: reset state
    chk("R8 cnt0", int'(cnt[0]), 0);
    chk("R8 holds", int'({wr_hold, rd_hold, wr_resync, rd_repeat}), 0);
    chk("R8 ptrs", int'({wr_ptr, rd_ptr}), 0);
    chk("R8 cfg_err", int'(cfg_err), 0);
    rst = 0;

    // R6: ch0 record: stop4 start2 rdstop0 rdstart2, repeat, frame2
    wcfg(BASE + 0, 8'd4);
    wcfg(BASE + 1, 8'd2);
    wcfg(BASE + 2, 8'd0);
    wcfg(BASE + 3, 8'd2);
    wcfg(BASE + 4, 8'h42);
    wcfg(BASE + 5, 8'hFF);
    step();

    for (int i = 0; i < NV; i++) begin
      wr_close[0] = VEC[i][24]; rd_close[0] = VEC[i][23]; wr_eosf[0] = VEC[i][22];
      cell_valid[0] = VEC[i][21]; cell_ptr_ok[0] = VEC[i][20];
      step();
      wr_close = '0; rd_close = '0; wr_eosf = '0; cell_valid = '0; cell_ptr_ok = '0;
      chk($sformatf("R1 cnt v%0d", i), int'(cnt[0]), int'(VEC[i][19:12]));
      chk($sformatf("R2 wr_hold v%0d", i), int'(wr_hold[0]), int'(VEC[i][11]));
      chk($sformatf("R5 rd_hold v%0d", i), int'(rd_hold[0]), int'(VEC[i][10]));
      chk($sformatf("R3 resync v%0d", i), int'(wr_resync[0]), int'(VEC[i][9]));
      chk($sformatf("R5 repeat v%0d", i), int'(rd_repeat[0]), int'(VEC[i][8]));
      chk($sformatf("R9 wr_ptr v%0d", i), int'(wr_ptr[0]), int'(VEC[i][7:4]));
      chk($sformatf("R9 rd_ptr v%0d", i), int'(rd_ptr[0]), int'(VEC[i][3:0]));
      if (i == 8) chk("R4 done v8", int'(resync_done[0]), 1);
    end
    // R10: untouched channel
    chk("R10 ch3 cnt", int'(cnt[3]), 0);
    chk("R10 ch3 ptr", int'(wr_ptr[3]), 0);

    // R6: out-of-range write must not alias onto ch0 writer-stop
    wcfg(BASE + NCH * 8, 8'd0);
    wr_close[0] = 1; step(); wr_close = '0;
    chk("R6 no alias cnt", int'(cnt[0]), 1);
    chk("R6 no alias hold", int'(wr_hold[0]), 0);

    // R4 structured on ch1: stop2 start1 rdstop0 rdstart1, structured, frame1
    wcfg(BASE + 8, 8'd2);
    wcfg(BASE + 9, 8'd1);
    wcfg(BASE + 10, 8'd0);
    wcfg(BASE + 11, 8'd1);
    wcfg(BASE + 12, 8'h81);
    step();
    chk("R7 ch1 ok", int'(cfg_err[1]), 0);
    wr_close[1] = 1; step();
    chk("R5 ch1 release", int'(rd_hold[1]), 0);
    step(); wr_close = '0;
    chk("R2 ch1 hold", int'(wr_hold[1]), 1);
    rd_close[1] = 1; step(); rd_close = '0;
    chk("R3 ch1 resync", int'(wr_resync[1]), 1);
    chk("R3 ch1 jump", int'(wr_ptr[1]), 0);
    cell_valid[1] = 1; step();
    chk("R4 structured wait", int'(wr_resync[1]), 1);
    cell_ptr_ok[1] = 1; step(); cell_valid = '0; cell_ptr_ok = '0;
    chk("R4 structured end", int'(wr_resync[1]), 0);
    chk("R4 done pulse", int'(resync_done[1]), 1);
    step();
    chk("R4 done one cycle", int'(resync_done[1]), 0);
    chk("R10 ch3 after", int'(cnt[3]), 0);

    // R7: ch2 reader gap 3-1=2 < frame 4
    chk("R7 ch2 before", int'(cfg_err[2]), 0);
    wcfg(BASE + 16 + 3, 8'd3);
    step();
    chk("R7 ch2 after", int'(cfg_err[2]), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule